// File: doc/BRIEF.md
# Serial-Bus Front End for a Multichannel Sampling Converter

This block is the two-wire serial slave that sits in front of a successive-approximation converter. It samples the clock and data lines in the system clock and finds start, repeated-start and stop conditions. It answers to a 7-bit address that combines a fixed five-bit prefix with two strap pins.

In a write, each data byte is a command. The command carries the input mode, the channel number and two power-down bits. As soon as the fourth command bit is clocked in, the block pulses a conversion-start strobe together with the captured mode and channel. It does not wait for the end of the byte.

In a read, the block returns the most recent 10-bit result, padded into a fixed two-byte frame. The data line is driven only through an open-drain pull-down enable. The converter core lies outside the block and delivers its result on a plain data/valid input.

Top module: `adc_i2c_front`

## Requirements
- R1: A falling data line while the clock is high is a start. This holds mid-byte and mid-transfer too, and the block then returns to address reception. A rising data line while the clock is high is a stop, after which the block is idle and has released the data line.
- R2: The address byte is received MSB first. Bits 7:3 must equal `ADDR_PREFIX` (default 10010), and bits 2:1 must equal `strap[1:0]`. Bit 0 is the direction, with 1 meaning read. Only a match is acknowledged. On a mismatch the data line stays released and no strobe is issued until the next start.
- R3: In a write, every received data byte is acknowledged by pulling the data line low through the ninth clock.
- R4: The command byte is laid out as follows. Bit 7 is the mode: 1 is single-ended and 0 is differential. Bits 6:4 are the channel. Bits 3:2 are the power-down bits, which appear on `pd_mode` once the byte is complete. Bits 1:0 are ignored.
- R5: `conv_start` is a one-cycle pulse. It is issued after the rising clock of the fourth command bit and before the fifth bit. `conv_se` and `conv_ch` carry that byte's mode and channel.
- R6: A read returns byte 0 as {0,0,0,0,D9..D6}, then byte 1 as {D5..D0,0,0}. The data comes from the last value presented with `res_valid`, sampled when the read address is acknowledged.
- R7: A read addressed before any `res_valid` returns two all-zero bytes.
- R8: If the master acknowledges byte 1, byte 1 is sent again.
- R9: A not-acknowledge from the master ends the read. The data line then stays released on later clocks.
- R10: A write of a command followed by a repeated start and a read returns the result without a stop in between.
- R11: `sda_oe` changes only in the cycle after a detected clock falling edge, start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| strap | input | 2 | Address select straps, address bits 2:1 |
| res_data | input | RES_W | Conversion result, straight binary |
| res_valid | input | 1 | Qualifies `res_data` for one cycle |
| conv_start | output | 1 | One-cycle conversion-start strobe |
| conv_se | output | 1 | Mode of the last command, 1 = single-ended |
| conv_ch | output | 3 | Channel of the last command |
| pd_mode | output | 2 | Power-down bits of the last complete command |

## Verification
The bench targets strobe timing: it records the bit position at which `conv_start` appears. A design that fires at the end of the byte, or one bit late, shows a position other than four.

Three read cases are checked:
- An empty read must return zeros rather than stale data.
- An acknowledged third byte must repeat byte 1 rather than wrap to byte 0.
- After a not-acknowledge, the slave must keep the line released on an extra clock.

A mismatched address must not be acknowledged, and the following byte must not trigger a strobe.

Starts and stops are placed mid-byte, and a repeated start links a write to a read. A design that fails to reset its bit counter misframes the next address, and the bench sees a missing acknowledge.

// File: rtl/adc_i2c_front.sv
module adc_i2c_front #(
  parameter logic [4:0] ADDR_PREFIX = 5'b10010,
  parameter int RES_W = 10,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       strap,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_valid,
  output logic             conv_start,
  output logic             conv_se,
  output logic [2:0]       conv_ch,
  output logic [1:0]       pd_mode
);
  localparam int FRAME_W = 16;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_MACK} st_t;

  logic [SYNC_LEN-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic rw, nack, byte_sel, res_ok;
  logic [RES_W-1:0] res_q;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1; sda_sh <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_LEN-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_LEN-2:0], sda_i};
      scl_q <= scl_sh[SYNC_LEN-1];
      sda_q <= sda_sh[SYNC_LEN-1];
    end

  wire scl_s     = scl_sh[SYNC_LEN-1];
  wire sda_s     = sda_sh[SYNC_LEN-1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire addr_hit  = (sh[7:3] == ADDR_PREFIX) && (sh[2:1] == strap);
  wire [FRAME_W-1:0] frame_nx = res_ok ? FRAME_W'({res_q, 2'b00}) : '0;
  wire [7:0] cur_byte = byte_sel ? frame[7:0] : frame[15:8];
  wire [2:0] bit_idx = 3'(7 - cnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; nack <= 1'b0;
      byte_sel <= 1'b0; res_ok <= 1'b0; res_q <= '0; frame <= '0;
      sda_oe <= 1'b0; conv_start <= 1'b0; conv_se <= 1'b0;
      conv_ch <= '0; pd_mode <= '0;
    end else begin
      conv_start <= 1'b0;
      if (res_valid) begin
        res_q <= res_data;
        res_ok <= 1'b1;
      end
      if (start_det) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (addr_hit) begin
                sda_oe <= 1'b1; rw <= sh[0]; st <= S_AACK;
              end else st <= S_IDLE;
            end
          S_AACK:
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                frame <= frame_nx; byte_sel <= 1'b0;
                sda_oe <= ~frame_nx[15]; st <= S_RD;
              end else begin
                sda_oe <= 1'b0; st <= S_WR;
              end
            end
          S_WR:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
              if (cnt == 4'd3) begin
                conv_start <= 1'b1;
                conv_se <= sh[2];
                conv_ch <= {sh[1:0], sda_s};
              end
            end else if (scl_fall && cnt == 4'd8) begin
              sda_oe <= 1'b1; pd_mode <= sh[3:2]; st <= S_WACK;
            end
          S_WACK:
            if (scl_fall) begin
              sda_oe <= 1'b0; cnt <= '0; st <= S_WR;
            end
          S_RD:
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; st <= S_MACK;
              end else sda_oe <= ~cur_byte[bit_idx];
            end
          S_MACK:
            if (scl_rise) nack <= sda_s;
            else if (scl_fall) begin
              if (nack) st <= S_IDLE;
              else begin
                byte_sel <= 1'b1; cnt <= '0;
                sda_oe <= ~frame[7]; st <= S_RD;
              end
            end
          default: st <= S_IDLE;
        endcase
      end
    end

  AST_OE_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> $past(scl_fall || start_det || stop_det)); // R11
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R5
  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(scl_rise) && $past(st == S_WR)); // R5
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R1
  AST_NO_ACK_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && scl_fall && cnt == 4'd8 && !addr_hit && !start_det && !stop_det) |=> !sda_oe); // R2
endmodule

// File: tb/sim_adc_i2c_front.sv
module sim_adc_i2c_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [9:0] res_data = '0;
  logic res_valid = 1'b0;
  wire sda_oe, conv_start, conv_se;
  wire [2:0] conv_ch;
  wire [1:0] pd_mode;
  wire sda = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0, strobes = 0, strobe_pos = 0, bitpos = 0, oe_bad = 0;
  logic last_se;
  logic [2:0] last_ch;
  logic prev_oe = 1'b0;

  always #10 clk = ~clk;

  adc_i2c_front u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda), .sda_oe(sda_oe),
    .strap(strap), .res_data(res_data), .res_valid(res_valid), .conv_start(conv_start),
    .conv_se(conv_se), .conv_ch(conv_ch), .pd_mode(pd_mode));

  always @(posedge clk) begin
    if (conv_start) begin
      strobes <= strobes + 1; strobe_pos <= bitpos;
      last_se <= conv_se; last_ch <= conv_ch;
    end
    if (sda_oe !== prev_oe && scl_m) oe_bad <= oe_bad + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; hw(7); scl_m = 1'b1; hw(10); scl_m = 1'b0; hw(3);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; hw(7); scl_m = 1'b1; hw(9); b = sda; hw(1); scl_m = 1'b0; hw(3);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hw(5); scl_m = 1'b1; hw(10); sda_m = 1'b0; hw(10); scl_m = 1'b0; hw(3);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hw(7); scl_m = 1'b1; hw(10); sda_m = 1'b1; hw(10);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 0; i < 8; i++) begin
      bitpos = i + 1; bit_out(b[7-i]);
    end
    bitpos = 0; bit_in(x); ack = ~x;
  endtask

  task automatic rd_byte(input logic mnack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) bit_in(b[7-i]);
    bit_out(mnack);
  endtask

  task automatic push_result(input logic [9:0] v);
    @(negedge clk); res_data = v; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sda released after reset", sda_oe, 0);
    chk("R5 no strobe after reset", strobes, 0);
    chk("R4 pd_mode reset", pd_mode, 0);
  endtask

  task automatic t_empty_read();
    logic a; logic [7:0] b0, b1;
    i2c_start(); wr_byte(8'h95, a);
    chk("R2 read address acked", a, 1);
    rd_byte(1'b0, b0); rd_byte(1'b1, b1); i2c_stop();
    chk("R7 empty byte0", b0, 0);
    chk("R7 empty byte1", b1, 0);
  endtask

  task automatic t_mismatch();
    logic a; int s0;
    s0 = strobes;
    i2c_start(); wr_byte(8'h90, a);
    chk("R2 wrong strap not acked", a, 0);
    wr_byte(8'hFF, a);
    chk("R2 byte after mismatch not acked", a, 0);
    i2c_stop();
    chk("R2 no strobe after mismatch", strobes, s0);
  endtask

  task automatic t_write();
    logic a; int s0;
    s0 = strobes;
    i2c_start(); wr_byte(8'h94, a);
    chk("R2 write address acked", a, 1);
    wr_byte(8'hDC, a);
    chk("R3 command acked", a, 1);
    chk("R5 one strobe", strobes, s0 + 1);
    chk("R5 strobe at fourth bit", strobe_pos, 4);
    chk("R4 single-ended", last_se, 1);
    chk("R4 channel 5", last_ch, 5);
    chk("R4 pd bits 11", pd_mode, 3);
    wr_byte(8'h22, a);
    chk("R3 second byte acked", a, 1);
    chk("R4 differential", last_se, 0);
    chk("R4 channel 2", last_ch, 2);
    chk("R4 pd bits 00, low bits ignored", pd_mode, 0);
    i2c_stop();
  endtask

  task automatic t_read();
    logic a, x; logic [7:0] b0, b1;
    push_result(10'h2A7);
    i2c_start(); wr_byte(8'h95, a);
    rd_byte(1'b0, b0); rd_byte(1'b1, b1);
    chk("R6 byte0 frame", b0, 8'h0A);
    chk("R6 byte1 frame", b1, 8'h9C);
    chk("R9 released after nack", sda_oe, 0);
    bit_in(x);
    chk("R9 line stays high after nack", x, 1);
    i2c_stop();
  endtask

  task automatic t_repeat_byte1();
    logic a; logic [7:0] b0, b1, b2;
    i2c_start(); wr_byte(8'h95, a);
    rd_byte(1'b0, b0); rd_byte(1'b0, b1); rd_byte(1'b1, b2);
    chk("R8 byte1 repeated", b2, 8'h9C);
    i2c_stop();
  endtask

  task automatic t_wr_rd();
    logic a; logic [7:0] b0, b1;
    push_result(10'h3FF);
    i2c_start(); wr_byte(8'h94, a); wr_byte(8'h14, a);
    chk("R4 channel 1", last_ch, 1);
    chk("R4 pd bits 01", pd_mode, 1);
    i2c_start(); wr_byte(8'h95, a);
    chk("R10 read acked after repeated start", a, 1);
    rd_byte(1'b0, b0); rd_byte(1'b1, b1);
    chk("R10 byte0", b0, 8'h0F);
    chk("R10 byte1", b1, 8'hFC);
    i2c_stop();
  endtask

  task automatic t_abort();
    logic a; logic [7:0] b0; int s0;
    s0 = strobes;
    i2c_start(); wr_byte(8'h94, a); bit_out(1'b1); bit_out(1'b1);
    i2c_stop();
    chk("R1 stop mid-byte releases", sda_oe, 0);
    chk("R1 no strobe from aborted byte", strobes, s0);
    i2c_start(); bit_out(1'b1); bit_out(1'b0);
    i2c_start(); wr_byte(8'h95, a);
    chk("R1 start mid-address reframes", a, 1);
    rd_byte(1'b1, b0);
    i2c_stop();
  endtask

  initial begin
    hw(5); rst_n = 1'b1; hw(5);
    t_reset();
    t_empty_read();
    t_mismatch();
    t_write();
    t_read();
    t_repeat_byte1();
    t_wr_rd();
    t_abort();
    chk("R11 sda_oe changes only with SCL low", oe_bad, 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule